// File: doc/BRIEF.md
# Frame Sync Flywheel Strategy Controller

This block decides when a serial telemetry stream is frame-aligned. It sits behind a sync-pattern correlator. For each bit time the correlator reports a detect pulse and the number of mismatched bits in the pattern ending at that bit. The block searches the stream for a usable pattern, then confirms that the pattern recurs one frame length later, then holds alignment. The three phases are SEARCH, VERIFY and LOCK. Thresholds on consecutive good and bad frames govern each change of phase.

Once a candidate is found, a bit-position counter runs against the programmed frame length. In VERIFY and LOCK a pattern is only taken inside an acceptance window centred on the expected position. The window covers the exact position, or ±1, ±2 or ±3 bits. Each accepted sync produces a frame-start pulse and the signed slip of the accepted position, and the counter realigns to where the sync actually fell. A missed frame keeps the timing at the expected position.

In fixed mode the programmed error tolerance applies throughout. In adaptive mode the tolerance tightens to the lowest mismatch count found during SEARCH, and that tightened value then governs VERIFY and LOCK. One bit is processed per clock. The frame length must be at least 8.

Top module: `fsync_flywheel`

## Requirements
- R1: After reset the state is SEARCH (code 0), `locked` is low and `frame_start` is low.
- R2: In fixed mode, SEARCH takes a detect at any bit position whose mismatch count is at most `cfg_tol`. It moves to VERIFY without a frame-start pulse. A detect whose count exceeds `cfg_tol` is ignored.
- R3: When `cfg_verify_good` is 0, an accepted pattern in SEARCH moves the state straight to LOCK.
- R4: In VERIFY and LOCK a detect is accepted only while the counter is within `cfg_slip` bits of the frame length. `cfg_slip` values 0, 1, 2 and 3 give windows of 1, 3, 5 and 7 bits. A detect outside the window has no effect.
- R5: An accepted sync in VERIFY or LOCK raises `frame_start` for one cycle, in the cycle after the detect. `sync_slip` then holds the actual position minus the expected position as a 3-bit two's-complement value. The next frame is timed from the actual position.
- R6: When several window positions qualify, the earliest one is taken, and later ones in the same window produce no pulse.
- R7: In VERIFY, `cfg_verify_good` consecutive good frames lead to LOCK, and `cfg_verify_bad` consecutive bad frames lead to SEARCH. A good frame clears the bad run.
- R8: In LOCK, `cfg_lock_bad` consecutive bad frames return the state directly to SEARCH. A bad frame is declared at the last window position, and the next frame is timed from the expected position.
- R9: In adaptive mode, the mismatch count of the first candidate becomes the working tolerance. A strictly better detect restarts the frame count and lowers the tolerance. SEARCH is left only when a detect within tolerance falls exactly one frame after the last candidate.
- R10: In adaptive mode, VERIFY and LOCK accept only detects whose count is within the tolerance set in SEARCH.
- R11: When an adaptive candidate fails at the end of its frame, or when SEARCH is re-entered, the working tolerance returns to `cfg_tol`.
- R12: `state` uses 0 for SEARCH, 1 for VERIFY and 2 for LOCK, and `locked` is high exactly when `state` is LOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| det | input | 1 | Correlator detect pulse for the current bit position |
| det_err | input | ERR_W | Mismatch count of the detected pattern |
| cfg_frame_len | input | LEN_W | Frame length in bits (at least 8) |
| cfg_slip | input | 2 | Slip half-width: 0..3 bits |
| cfg_verify_good | input | CNT_W | Good frames needed to leave VERIFY for LOCK |
| cfg_verify_bad | input | CNT_W | Bad frames that send VERIFY back to SEARCH |
| cfg_lock_bad | input | CNT_W | Bad frames that send LOCK back to SEARCH |
| cfg_tol | input | ERR_W | Programmed mismatch tolerance |
| cfg_adaptive | input | 1 | 1 selects the adaptive strategy |
| state | output | 2 | Current strategy state |
| locked | output | 1 | High while in LOCK |
| frame_start | output | 1 | One-cycle pulse per accepted sync in VERIFY or LOCK |
| sync_slip | output | 3 | Signed offset of the last accepted sync |

## Verification
A wrong frame counter shows up at the ports within one frame. The window no longer lines up, so the next on-time detect is rejected, or an off-time detect is taken, and `sync_slip` shows the wrong offset. Wrong good or bad run counts change the cycle in which `state` moves. The stimulus brackets each threshold with a check one bit before the expected transition and one at it. A wrong adaptive tolerance is exposed by a detect that sits between the tightened and the programmed tolerance, which one frame later must not produce a pulse.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [1:0] {
        FS_SEARCH = 2'd0,
        FS_VERIFY = 2'd1,
        FS_LOCK   = 2'd2
    } fs_state_e;

    // magnitude of a 3-bit two's-complement slip value
    function automatic logic [2:0] slip_mag(input logic [2:0] s);
        return s[2] ? 3'(-s) : s;
    endfunction

endpackage

// File: rtl/fsw_pos_timer.sv
module fsw_pos_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             restart,
    input  logic             realign,
    input  logic             run,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [1:0]       half,
    output logic             in_win,
    output logic             at_end,
    output logic             win_end,
    output logic [2:0]       offset
);
    localparam int PW = LEN_W + 1;

    logic [PW-1:0] pos;
    logic [PW-1:0] len_x;
    logic [PW-1:0] lo;
    logic [PW-1:0] hi;

    assign len_x   = {1'b0, frame_len};
    assign lo      = len_x - PW'(half);
    assign hi      = len_x + PW'(half);
    assign in_win  = (pos >= lo) && (pos <= hi);
    assign at_end  = (pos == len_x);
    assign win_end = (pos == hi);
    assign offset  = 3'(pos - len_x);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
        end else if (restart) begin
            pos <= PW'(1);
        end else if (realign) begin
            pos <= PW'(half) + PW'(1);
        end else if (run && (pos != '1)) begin
            pos <= pos + 1'b1;
        end
    end

    a_r5_restart_one: assert property (@(posedge clk) disable iff (rst)
        (restart && !clear) |=> (pos == PW'(1)));

    a_r8_realign_expected: assert property (@(posedge clk) disable iff (rst)
        (realign && !clear && !restart) |=> (pos == PW'($past(half)) + PW'(1)));

endmodule

// File: rtl/fsw_run_ctr.sv
module fsw_run_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             good,
    input  logic             bad,
    output logic [CNT_W-1:0] good_cnt,
    output logic [CNT_W-1:0] bad_cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            good_cnt <= '0;
            bad_cnt  <= '0;
        end else if (good) begin
            bad_cnt <= '0;
            if (good_cnt != '1) good_cnt <= good_cnt + 1'b1;
        end else if (bad) begin
            good_cnt <= '0;
            if (bad_cnt != '1) bad_cnt <= bad_cnt + 1'b1;
        end
    end

    a_r7_good_clears_bad: assert property (@(posedge clk) disable iff (rst)
        (good && !clear) |=> (bad_cnt == '0));

    a_r7_bad_clears_good: assert property (@(posedge clk) disable iff (rst)
        (bad && !good && !clear) |=> (good_cnt == '0));

endmodule

// File: rtl/fsw_tol_reg.sv
module fsw_tol_reg #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             load,
    input  logic [ERR_W-1:0] load_val,
    input  logic [ERR_W-1:0] cfg_tol,
    output logic [ERR_W-1:0] tol
);
    always_ff @(posedge clk) begin
        if (rst || reload) begin
            tol <= cfg_tol;
        end else if (load) begin
            tol <= load_val;
        end
    end

    a_r11_reload_programmed: assert property (@(posedge clk) disable iff (rst)
        reload |=> (tol == $past(cfg_tol)));

    a_r9_take_candidate: assert property (@(posedge clk) disable iff (rst)
        (load && !reload) |=> (tol == $past(load_val)));

endmodule

// File: rtl/fsync_flywheel.sv
module fsync_flywheel
    import fsw_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int ERR_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             det,
    input  logic [ERR_W-1:0] det_err,
    input  logic [LEN_W-1:0] cfg_frame_len,
    input  logic [1:0]       cfg_slip,
    input  logic [CNT_W-1:0] cfg_verify_good,
    input  logic [CNT_W-1:0] cfg_verify_bad,
    input  logic [CNT_W-1:0] cfg_lock_bad,
    input  logic [ERR_W-1:0] cfg_tol,
    input  logic             cfg_adaptive,
    output logic [1:0]       state,
    output logic             locked,
    output logic             frame_start,
    output logic [2:0]       sync_slip
);
    function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] thr);
        return ({1'b0, cnt} + 1'b1) >= {1'b0, thr};
    endfunction

    fs_state_e        st_q, st_d, lead_st;
    logic             cand_q, cand_d;
    logic             fs_d;
    logic [2:0]       slip_d;
    logic             t_clear, t_restart, t_realign, t_run;
    logic             c_clear, c_good, c_bad;
    logic             tol_reload, tol_load;
    logic             in_win, at_end, win_end;
    logic [2:0]       offset;
    logic [CNT_W-1:0] good_cnt, bad_cnt;
    logic [ERR_W-1:0] tol_q, tol_use;
    logic             acc_ok, better;

    fsw_pos_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst(rst), .clear(t_clear), .restart(t_restart),
        .realign(t_realign), .run(t_run), .frame_len(cfg_frame_len),
        .half(cfg_slip), .in_win(in_win), .at_end(at_end),
        .win_end(win_end), .offset(offset)
    );

    fsw_run_ctr #(.CNT_W(CNT_W)) u_runs (
        .clk(clk), .rst(rst), .clear(c_clear), .good(c_good), .bad(c_bad),
        .good_cnt(good_cnt), .bad_cnt(bad_cnt)
    );

    fsw_tol_reg #(.ERR_W(ERR_W)) u_tol (
        .clk(clk), .rst(rst), .reload(tol_reload), .load(tol_load),
        .load_val(det_err), .cfg_tol(cfg_tol), .tol(tol_q)
    );

    // the tightened tolerance applies only once an adaptive candidate exists
    assign tol_use = (cfg_adaptive && ((st_q != FS_SEARCH) || cand_q)) ? tol_q : cfg_tol;
    assign acc_ok  = det && (det_err <= tol_use);
    assign better  = det && (det_err < tol_q);
    assign lead_st = (cfg_verify_good == '0) ? FS_LOCK : FS_VERIFY;

    always_comb begin
        st_d       = st_q;
        cand_d     = cand_q;
        fs_d       = 1'b0;
        slip_d     = sync_slip;
        t_clear    = 1'b0;
        t_restart  = 1'b0;
        t_realign  = 1'b0;
        t_run      = 1'b0;
        c_clear    = 1'b0;
        c_good     = 1'b0;
        c_bad      = 1'b0;
        tol_reload = 1'b0;
        tol_load   = 1'b0;
        case (st_q)
            FS_SEARCH: begin
                if (!cfg_adaptive || !cand_q) begin
                    if (acc_ok) begin
                        t_restart = 1'b1;
                        c_clear   = 1'b1;
                        if (cfg_adaptive) begin
                            cand_d   = 1'b1;
                            tol_load = 1'b1;
                        end else begin
                            st_d = lead_st;
                        end
                    end else begin
                        t_clear = 1'b1;
                    end
                end else if (better) begin
                    t_restart = 1'b1;
                    tol_load  = 1'b1;
                end else if (at_end) begin
                    cand_d = 1'b0;
                    if (acc_ok) begin
                        t_restart = 1'b1;
                        c_clear   = 1'b1;
                        st_d      = lead_st;
                    end else begin
                        t_clear    = 1'b1;
                        tol_reload = 1'b1;
                    end
                end else begin
                    t_run = 1'b1;
                end
            end
            default: begin
                if (in_win && acc_ok) begin
                    t_restart = 1'b1;
                    fs_d      = 1'b1;
                    slip_d    = offset;
                    if ((st_q == FS_VERIFY) && reached(good_cnt, cfg_verify_good)) begin
                        st_d    = FS_LOCK;
                        c_clear = 1'b1;
                    end else begin
                        c_good = 1'b1;
                    end
                end else if (win_end) begin
                    if (reached(bad_cnt, (st_q == FS_LOCK) ? cfg_lock_bad : cfg_verify_bad)) begin
                        st_d       = FS_SEARCH;
                        cand_d     = 1'b0;
                        t_clear    = 1'b1;
                        c_clear    = 1'b1;
                        tol_reload = 1'b1;
                    end else begin
                        c_bad     = 1'b1;
                        t_realign = 1'b1;
                    end
                end else begin
                    t_run = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= FS_SEARCH;
            cand_q      <= 1'b0;
            frame_start <= 1'b0;
            sync_slip   <= '0;
        end else begin
            st_q        <= st_d;
            cand_q      <= cand_d;
            frame_start <= fs_d;
            sync_slip   <= slip_d;
        end
    end

    assign state  = st_q;
    assign locked = (st_q == FS_LOCK);

    a_r5_pulse_not_in_search: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (st_q != FS_SEARCH));

    a_r4_slip_in_window: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (slip_mag(sync_slip) <= {1'b0, $past(cfg_slip)}));

    a_r8_lock_exits_to_search: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) == FS_LOCK) && (st_q != FS_LOCK)) |-> (st_q == FS_SEARCH));

    a_r3_skip_verify_only_at_zero: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) == FS_SEARCH) && (st_q == FS_LOCK)) |-> ($past(cfg_verify_good) == '0));

    a_r9_candidate_in_search: assert property (@(posedge clk) disable iff (rst)
        cand_q |-> (st_q == FS_SEARCH));

    a_r12_legal_state: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_SEARCH) || (st_q == FS_VERIFY) || (st_q == FS_LOCK));

endmodule

// File: tb/fsync_flywheel_bench.sv
`timescale 1ns/1ps
module fsync_flywheel_bench;
    localparam int LEN_W = 12;
    localparam int ERR_W = 4;
    localparam int CNT_W = 4;

    typedef struct {
        bit         chk;
        logic [1:0] st;
        bit         fs;
        logic [2:0] slip;
        string      tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             det = 1'b0;
    logic [ERR_W-1:0] det_err = '0;
    logic [LEN_W-1:0] cfg_frame_len = 12'd16;
    logic [1:0]       cfg_slip = 2'd1;
    logic [CNT_W-1:0] cfg_verify_good = 4'd2;
    logic [CNT_W-1:0] cfg_verify_bad = 4'd2;
    logic [CNT_W-1:0] cfg_lock_bad = 4'd3;
    logic [ERR_W-1:0] cfg_tol = 4'd3;
    logic             cfg_adaptive = 1'b0;
    logic [1:0]       state;
    logic             locked;
    logic             frame_start;
    logic [2:0]       sync_slip;

    logic [1:0]       n_slip;
    logic [CNT_W-1:0] n_vgood;
    logic             n_adapt;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    t = 0;
    int    t0 = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    fsync_flywheel #(.LEN_W(LEN_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) u_fsync_flywheel (
        .clk(clk), .rst(rst), .det(det), .det_err(det_err),
        .cfg_frame_len(cfg_frame_len), .cfg_slip(cfg_slip),
        .cfg_verify_good(cfg_verify_good), .cfg_verify_bad(cfg_verify_bad),
        .cfg_lock_bad(cfg_lock_bad), .cfg_tol(cfg_tol), .cfg_adaptive(cfg_adaptive),
        .state(state), .locked(locked), .frame_start(frame_start), .sync_slip(sync_slip)
    );

    // monitor: compares each queued expectation one step after it was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.chk) begin
                    n_cmp++;
                    if (state !== it.st || locked !== (it.st == 2'd2) ||
                        frame_start !== it.fs || (it.fs && sync_slip !== it.slip)) begin
                        n_bad++;
                        $display("FAIL %s: got state=%0d locked=%0b fs=%0b slip=%0d, exp state=%0d locked=%0b fs=%0b slip=%0d",
                                 it.tag, state, locked, frame_start, sync_slip,
                                 it.st, (it.st == 2'd2), it.fs, it.slip);
                    end
                end
            end
        end
    end

    task automatic step(input bit d, input int e, input bit chk, input logic [1:0] st,
                        input bit fs, input logic [2:0] slip, input string tag);
        item_t it;
        @(negedge clk);
        det     = d;
        det_err = ERR_W'(e);
        it.chk = chk; it.st = st; it.fs = fs; it.slip = slip; it.tag = tag;
        q.push_back(it);
        t++;
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 2'd0, 1'b0, 3'd0, "");
    endtask

    task automatic go(input int k);
        while (t + 1 - t0 < k) idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        det = 1'b0;
        cfg_slip = n_slip;
        cfg_verify_good = n_vgood;
        cfg_adaptive = n_adapt;
        @(negedge clk);
        rst = 1'b0;
        t = 0;
        t0 = 0;
    endtask

    initial begin
        n_slip = 2'd1; n_vgood = 4'd2; n_adapt = 1'b0;
        do_reset();
        step(1'b0, 0, 1'b1, 2'd0, 1'b0, 3'd0, "R1 reset state");
        step(1'b1, 4, 1'b1, 2'd0, 1'b0, 3'd0, "R2 over tolerance ignored");
        step(1'b1, 2, 1'b1, 2'd1, 1'b0, 3'd0, "R2 search to verify"); t0 = t;
        go(16); step(1'b1, 0, 1'b1, 2'd1, 1'b1, 3'd0, "R5 on-time sync"); t0 = t;
        go(17); step(1'b1, 3, 1'b1, 2'd2, 1'b1, 3'd1, "R7 late sync reaches lock"); t0 = t;
        go(15); step(1'b1, 0, 1'b1, 2'd2, 1'b1, 3'd7, "R5 realigned to actual"); t0 = t;
        go(15); step(1'b1, 0, 1'b1, 2'd2, 1'b1, 3'd7, "R6 earliest taken"); t0 = t;
        step(1'b1, 0, 1'b1, 2'd2, 1'b0, 3'd0, "R6 later detect ignored");
        go(13); step(1'b1, 0, 1'b1, 2'd2, 1'b0, 3'd0, "R4 outside window");
        go(48); step(1'b0, 0, 1'b1, 2'd2, 1'b0, 3'd0, "R8 two misses keep lock");
        step(1'b0, 0, 1'b1, 2'd0, 1'b0, 3'd0, "R8 third miss to search");

        do_reset();
        step(1'b1, 1, 1'b1, 2'd1, 1'b0, 3'd0, "R2 acquire"); t0 = t;
        go(17); step(1'b0, 0, 1'b1, 2'd1, 1'b0, 3'd0, "R7 one bad stays verify");
        go(32); step(1'b1, 0, 1'b1, 2'd1, 1'b1, 3'd0, "R8 flywheel keeps timing"); t0 = t;
        go(17); step(1'b0, 0, 1'b1, 2'd1, 1'b0, 3'd0, "R7 good cleared bad run");
        go(33); step(1'b0, 0, 1'b1, 2'd0, 1'b0, 3'd0, "R7 two bad to search");

        n_vgood = 4'd0;
        do_reset();
        step(1'b1, 3, 1'b1, 2'd2, 1'b0, 3'd0, "R3 direct lock");

        n_slip = 2'd3;
        do_reset();
        step(1'b1, 0, 1'b1, 2'd2, 1'b0, 3'd0, "R3 lock for wide window"); t0 = t;
        go(19); step(1'b1, 0, 1'b1, 2'd2, 1'b1, 3'd3, "R4 plus three"); t0 = t;
        go(13); step(1'b1, 0, 1'b1, 2'd2, 1'b1, 3'd5, "R4 minus three");

        n_slip = 2'd0;
        do_reset();
        step(1'b1, 0, 1'b1, 2'd2, 1'b0, 3'd0, "R3 lock for exact window"); t0 = t;
        go(17); step(1'b1, 0, 1'b1, 2'd2, 1'b0, 3'd0, "R4 exact window rejects +1");

        n_slip = 2'd1; n_vgood = 4'd1; n_adapt = 1'b1;
        do_reset();
        step(1'b1, 3, 1'b1, 2'd0, 1'b0, 3'd0, "R9 candidate stays in search"); t0 = t;
        go(5);  step(1'b1, 1, 1'b1, 2'd0, 1'b0, 3'd0, "R9 better restarts"); t0 = t;
        go(16); step(1'b1, 1, 1'b1, 2'd1, 1'b0, 3'd0, "R9 end of frame to verify"); t0 = t;
        go(16); step(1'b1, 2, 1'b1, 2'd1, 1'b0, 3'd0, "R10 tightened tolerance rejects");
        step(1'b0, 0, 1'b1, 2'd1, 1'b0, 3'd0, "R10 bad frame stays verify");
        go(32); step(1'b1, 1, 1'b1, 2'd2, 1'b1, 3'd0, "R10 within tolerance locks");

        do_reset();
        step(1'b1, 2, 1'b1, 2'd0, 1'b0, 3'd0, "R9 candidate"); t0 = t;
        go(16); step(1'b0, 0, 1'b1, 2'd0, 1'b0, 3'd0, "R11 candidate dropped");
        go(18); step(1'b1, 3, 1'b1, 2'd0, 1'b0, 3'd0, "R11 reloaded tolerance"); t0 = t;
        go(16); step(1'b1, 3, 1'b1, 2'd1, 1'b0, 3'd0, "R11 advance at reloaded tolerance");

        idle(); idle();
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got no completion, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule